// File: doc/BRIEF.md
# Flash Block Lock Controller

This block keeps the protection state of a small array of flash blocks and decodes the bus writes that change it. Each block carries a lock bit and a sticky lock-down bit. A lock change takes two writes to the same block address: a setup write, then a confirm write. The confirm value picks lock, unlock or lock-down. Program and erase logic reads one writable flag per block. That flag is clear whenever the block is protected.

A write-protect pin works only on blocks whose lock-down bit is set. While the pin is high, such a block stays protected and unlock commands are refused. Once the pin is low, software can unlock and re-lock the block again. Only reset clears a lock-down bit. A separate write switches the bus into identifier mode. A read at a block's base address plus two then returns that block's status. Another write returns the bus to array mode, where this block drives zeros.

Top module: `flk_ctrl`

## Requirements
- R1: After a synchronous reset every block is locked with its lock-down bit clear, `writable_o` is all zeros, and the bus is in array mode.
- R2: Write 60h to a block address, then 01h to the same block address. After the second write, that block is locked and no other block changes.
- R3: Write 60h, then D0h, to the same block address. This clears the block's lock, and its `writable_o` bit reads 1 on the following cycle, unless the block is held by R5.
- R4: Write 60h, then 2Fh, to the same block address. This sets both the lock bit and the lock-down bit of that block.
- R5: While `wp_i` is 1, a block with its lock-down bit set reports status 3'b011. Unlock commands to it have no effect.
- R6: While `wp_i` is 0, a locked block with its lock-down bit set reports status 3'b111. Unlock and lock commands then take effect; an unlocked lock-down block reports 3'b110.
- R7: Raising `wp_i` forces every block with its lock-down bit set to read as locked (writable 0) in the same cycle, even if software had unlocked it.
- R8: No bus command clears a lock-down bit. Only reset does.
- R9: Writing 90h (with no setup pending) enters identifier mode. A read there returns a status word. Bit 2 is the inverse of `wp_i`, bit 1 is the lock-down bit, bit 0 is the effective lock. Higher bits are zero. The read must be at offset 2 within the addressed block (address bits [3:0] in the default configuration). Reads at any other offset return zero.
- R10: Writing FFh (with no setup pending) returns to array mode. In array mode `rdata_o` is zero.
- R11: A confirm write that follows a setup aborts the sequence with no block change in two cases: its value is anything other than 01h, D0h or 2Fh, or it goes to a different block. The next write after an abort is decoded as a fresh command.
- R12: `wp_i` has no effect on any block whose lock-down bit is clear.
- R13: `writable_o[b]` is the inverse of block b's effective lock, where effective lock = lock OR (lock-down AND `wp_i`). It follows `wp_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Bus write strobe, sampled on the rising edge |
| addr_i | input | ADDR_W (7) | Bus address: upper bits select the block, lower OFF_W bits the offset |
| wdata_i | input | DATA_W (8) | Bus write data |
| rdata_o | output | DATA_W (8) | Bus read data, combinational from address and state |
| wp_i | input | 1 | Write-protect pin, active high |
| writable_o | output | NUM_BLK (8) | Per-block flag, 1 when program or erase is allowed |

## Verification
Lock state changes on the rising edge that samples the confirm write. The bench drives every write on a falling edge and releases it on the next falling edge. At that point the new `writable_o` value is already stable, and it is checked there. Changes to `writable_o` caused by `wp_i`, and all status reads, are combinational. They are sampled one time unit after the pin or address is driven, with no clock edge in between. The sweeps cover every block and every command, under both pin levels, plus all 253 invalid confirm values. A reference model in the bench, updated write by write from the requirements, supplies the expected values.

// File: rtl/flk_pkg.sv
package flk_pkg;
    localparam logic [7:0] OP_SETUP  = 8'h60;
    localparam logic [7:0] OP_LOCK   = 8'h01;
    localparam logic [7:0] OP_UNLOCK = 8'hD0;
    localparam logic [7:0] OP_LDN    = 8'h2F;
    localparam logic [7:0] OP_ID     = 8'h90;
    localparam logic [7:0] OP_ARRAY  = 8'hFF;
    localparam int unsigned STATUS_OFS = 2;

    typedef enum logic [2:0] {
        K_NONE,
        K_SETUP,
        K_LOCK,
        K_UNLOCK,
        K_LDN,
        K_ID,
        K_ARRAY
    } op_kind_e;

    typedef enum logic {
        M_ARRAY,
        M_ID
    } bus_mode_e;
endpackage

// File: rtl/flk_cmd_dec.sv
module flk_cmd_dec #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] wdata_i,
    output flk_pkg::op_kind_e kind_o
);
    import flk_pkg::*;

    logic [7:0] low_byte;
    logic       hi_zero;

    assign low_byte = wdata_i[7:0];

    generate
        if (DATA_W > 8) begin : g_wide
            assign hi_zero = (wdata_i[DATA_W-1:8] == '0);
        end else begin : g_narrow
            assign hi_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        kind_o = K_NONE;
        if (hi_zero) begin
            unique case (low_byte)
                OP_SETUP:  kind_o = K_SETUP;
                OP_LOCK:   kind_o = K_LOCK;
                OP_UNLOCK: kind_o = K_UNLOCK;
                OP_LDN:    kind_o = K_LDN;
                OP_ID:     kind_o = K_ID;
                OP_ARRAY:  kind_o = K_ARRAY;
                default:   kind_o = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/flk_blk_cell.sv
module flk_blk_cell (
    input  logic clk_i,
    input  logic rst_i,
    input  logic set_lock_i,
    input  logic clr_lock_i,
    input  logic set_ldn_i,
    input  logic wp_i,
    output logic eff_lock_o,
    output logic ldn_o
);
    typedef struct packed {
        logic lock;
        logic ldn;
    } cell_t;

    cell_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (set_ldn_i) begin
            c_d.lock = 1'b1;
            c_d.ldn  = 1'b1;
        end else if (set_lock_i) begin
            c_d.lock = 1'b1;
        end else if (clr_lock_i && !(c_q.ldn && wp_i)) begin
            c_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            c_q <= '{lock: 1'b1, ldn: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign eff_lock_o = c_q.lock | (c_q.ldn & wp_i);
    assign ldn_o      = c_q.ldn;
endmodule

// File: rtl/flk_ctrl.sv
module flk_ctrl #(
    parameter int NUM_BLK = 8,
    parameter int OFF_W   = 4,
    parameter int DATA_W  = 8,
    localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
    localparam int ADDR_W = BLK_W + OFF_W
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic               wp_i,
    output logic [NUM_BLK-1:0] writable_o
);
    import flk_pkg::*;

    typedef struct packed {
        bus_mode_e        mode;
        logic             pend;
        logic [BLK_W-1:0] blk;
    } seq_t;

    seq_t st_d, st_q;

    op_kind_e         kind;
    logic [BLK_W-1:0] addr_blk;
    logic [OFF_W-1:0] addr_ofs;
    logic [NUM_BLK-1:0] set_lock, clr_lock, set_ldn;
    logic [NUM_BLK-1:0] eff_vec, ldn_vec;
    logic             pend_q;
    logic [BLK_W-1:0] setup_blk_q;
    logic             id_mode_q;

    assign addr_blk = addr_i[ADDR_W-1:OFF_W];
    assign addr_ofs = addr_i[OFF_W-1:0];

    flk_cmd_dec #(.DATA_W(DATA_W)) u_dec (
        .wdata_i (wdata_i),
        .kind_o  (kind)
    );

    always_comb begin
        st_d     = st_q;
        set_lock = '0;
        clr_lock = '0;
        set_ldn  = '0;
        if (wr_en_i) begin
            if (st_q.pend) begin
                st_d.pend = 1'b0;
                if (addr_blk == st_q.blk) begin
                    unique case (kind)
                        K_LOCK:   set_lock[st_q.blk] = 1'b1;
                        K_UNLOCK: clr_lock[st_q.blk] = 1'b1;
                        K_LDN:    set_ldn[st_q.blk]  = 1'b1;
                        default:  ;
                    endcase
                end
            end else begin
                unique case (kind)
                    K_SETUP: begin
                        st_d.pend = 1'b1;
                        st_d.blk  = addr_blk;
                    end
                    K_ID:    st_d.mode = M_ID;
                    K_ARRAY: st_d.mode = M_ARRAY;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{mode: M_ARRAY, pend: 1'b0, blk: '0};
        end else begin
            st_q <= st_d;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_BLK; gi++) begin : g_cell
            flk_blk_cell u_cell (
                .clk_i      (clk_i),
                .rst_i      (rst_i),
                .set_lock_i (set_lock[gi]),
                .clr_lock_i (clr_lock[gi]),
                .set_ldn_i  (set_ldn[gi]),
                .wp_i       (wp_i),
                .eff_lock_o (eff_vec[gi]),
                .ldn_o      (ldn_vec[gi])
            );
        end
    endgenerate

    assign writable_o = ~eff_vec;

    always_comb begin
        rdata_o = '0;
        if (st_q.mode == M_ID && addr_ofs == OFF_W'(STATUS_OFS)) begin
            rdata_o[2] = ~wp_i;
            rdata_o[1] = ldn_vec[addr_blk];
            rdata_o[0] = eff_vec[addr_blk];
        end
    end

    assign pend_q      = st_q.pend;
    assign setup_blk_q = st_q.blk;
    assign id_mode_q   = (st_q.mode == M_ID);
endmodule

// File: rtl/flk_ctrl_chk.sv
module flk_ctrl_chk #(
    parameter int NUM_BLK = 8,
    parameter int OFF_W   = 4,
    parameter int DATA_W  = 8,
    parameter int BLK_W   = 3
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               wr_en_i,
    input logic [BLK_W+OFF_W-1:0] addr_i,
    input logic [DATA_W-1:0]  wdata_i,
    input logic [DATA_W-1:0]  rdata_o,
    input logic               wp_i,
    input logic [NUM_BLK-1:0] writable_o,
    input logic [NUM_BLK-1:0] ldn_vec,
    input logic               pend_q,
    input logic [BLK_W-1:0]   setup_blk_q,
    input logic               id_mode_q
);
    logic good_confirm;
    logic same_blk;
    assign good_confirm = (wdata_i == DATA_W'(8'h01)) || (wdata_i == DATA_W'(8'hD0))
                       || (wdata_i == DATA_W'(8'h2F));
    assign same_blk = (addr_i[BLK_W+OFF_W-1:OFF_W] == setup_blk_q);

    AST_RESET_LOCKED: assert property (@(posedge clk_i) $fell(rst_i) |-> (writable_o == '0 && ldn_vec == '0)); // R1

    AST_LDN_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        (($past(ldn_vec) & ~ldn_vec) == '0)); // R8

    AST_ABORT_BAD: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && pend_q && (!good_confirm || !same_blk)) |=> $stable(ldn_vec) && !pend_q); // R11

    AST_UNLOCK_OK: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && pend_q && same_blk && wdata_i == DATA_W'(8'hD0)
         && !(wp_i && ldn_vec[setup_blk_q]))
        |=> (writable_o[$past(setup_blk_q)] || (wp_i && ldn_vec[$past(setup_blk_q)]))); // R3

    AST_ARRAY_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !id_mode_q |-> rdata_o == '0); // R10

    genvar gb;
    generate
        for (gb = 0; gb < NUM_BLK; gb++) begin : g_wp
            AST_WP_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
                (wp_i && ldn_vec[gb]) |-> !writable_o[gb]); // R7
        end
    endgenerate
endmodule

bind flk_ctrl flk_ctrl_chk #(
    .NUM_BLK (NUM_BLK),
    .OFF_W   (OFF_W),
    .DATA_W  (DATA_W),
    .BLK_W   (BLK_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .wp_i        (wp_i),
    .writable_o  (writable_o),
    .ldn_vec     (ldn_vec),
    .pend_q      (pend_q),
    .setup_blk_q (setup_blk_q),
    .id_mode_q   (id_mode_q)
);

// File: tb/tb_flk_ctrl.sv
module tb_flk_ctrl;
    localparam int NB     = 8;
    localparam int OFFW   = 4;
    localparam int DW     = 8;
    localparam int BW     = 3;
    localparam int AW     = BW + OFFW;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_i;
    logic          wr_en_i;
    logic [AW-1:0] addr_i;
    logic [DW-1:0] wdata_i;
    logic [DW-1:0] rdata_o;
    logic          wp_i;
    logic [NB-1:0] writable_o;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic m_lock [NB];
    logic m_ldn  [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    flk_ctrl #(.NUM_BLK(NB), .OFF_W(OFFW), .DATA_W(DW)) dut (
        .clk_i      (clk),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .wp_i       (wp_i),
        .writable_o (writable_o)
    );

    function automatic logic [AW-1:0] baddr(int b, int ofs);
        return AW'((b << OFFW) + ofs);
    endfunction

    function automatic logic m_eff(int b);
        return m_lock[b] | (m_ldn[b] & wp_i);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_i = 1'b1;
        repeat (2) @(negedge clk);
        rst_i = 1'b0;
        for (int b = 0; b < NB; b++) begin
            m_lock[b] = 1'b1;
            m_ldn[b]  = 1'b0;
        end
    endtask

    task automatic bus_wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        wr_en_i = 1'b1;
        addr_i  = a;
        wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic lock_cmd(int b, logic [DW-1:0] code);
        bus_wr(baddr(b, 0), 8'h60);
        bus_wr(baddr(b, 5), code);
        if (code == 8'h01) m_lock[b] = 1'b1;
        else if (code == 8'h2F) begin m_lock[b] = 1'b1; m_ldn[b] = 1'b1; end
        else if (code == 8'hD0 && !(m_ldn[b] && wp_i)) m_lock[b] = 1'b0;
    endtask

    task automatic check_wr(string req);
        logic [NB-1:0] e;
        #1;
        for (int b = 0; b < NB; b++) e[b] = ~m_eff(b);
        check(req, 32'(writable_o), 32'(e));
    endtask

    task automatic check_status(string req, int b);
        addr_i = baddr(b, 2);
        #1;
        check(req, 32'(rdata_o), {29'b0, ~wp_i, m_ldn[b], m_eff(b)});
    endtask

    task automatic check_all_status(string req);
        for (int b = 0; b < NB; b++) check_status(req, b);
    endtask

    initial begin
        rst_i = 1'b1; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0; wp_i = 1'b0;
        do_reset();

        // R1: reset state, array mode reads zero
        check("R1", 32'(writable_o), 32'h0);
        addr_i = baddr(3, 2); #1;
        check("R1", 32'(rdata_o), 32'h0);
        bus_wr(baddr(0, 0), 8'h90);
        check_all_status("R1");

        // R3 then R2: unlock and relock each block one at a time
        for (int b = 0; b < NB; b++) begin lock_cmd(b, 8'hD0); check_wr("R3"); end
        for (int b = 0; b < NB; b++) begin lock_cmd(b, 8'h01); check_wr("R2"); end
        for (int b = 0; b < NB; b++) lock_cmd(b, 8'hD0);
        check_all_status("R3");

        // R12: pin has no effect on blocks without lock-down
        wp_i = 1'b1; check_wr("R12");
        wp_i = 1'b0; check_wr("R12");

        // R4: lock down the odd blocks
        for (int b = 1; b < NB; b += 2) begin lock_cmd(b, 8'h2F); check_wr("R4"); end
        check_all_status("R4");

        // R5: pin high, unlock refused on lock-down blocks, status 011
        wp_i = 1'b1;
        for (int b = 0; b < NB; b++) lock_cmd(b, 8'h01);
        for (int b = 0; b < NB; b++) begin lock_cmd(b, 8'hD0); check_wr("R5"); end
        check_status("R5", 1);
        check("R5", 32'(rdata_o), 32'h3);
        check_all_status("R5");

        // R6: pin low, status 111, unlock then relock take effect
        wp_i = 1'b0;
        check_status("R6", 3);
        check("R6", 32'(rdata_o), 32'h7);
        for (int b = 1; b < NB; b += 2) begin lock_cmd(b, 8'hD0); check_wr("R6"); end
        check_status("R6", 5);
        check("R6", 32'(rdata_o), 32'h6);

        // R7 and R13: raising the pin forces lock-down blocks locked at once
        wp_i = 1'b1; check_wr("R7");
        check("R13", 32'(writable_o), 32'h55);
        wp_i = 1'b0; check_wr("R13");
        check("R13", 32'(writable_o), 32'hFF);
        lock_cmd(5, 8'h01); check_wr("R6");

        // R8: no command clears lock-down
        for (int b = 0; b < NB; b++) begin
            lock_cmd(b, 8'h01); lock_cmd(b, 8'hD0); lock_cmd(b, 8'hFF); lock_cmd(b, 8'h90);
        end
        wp_i = 1'b1; check_wr("R8");
        check_all_status("R8");

        // R11: every invalid confirm aborts
        wp_i = 1'b0;
        for (int v = 0; v < 256; v++) begin
            if (v != 8'h01 && v != 8'hD0 && v != 8'h2F) begin
                lock_cmd(2, DW'(v)); lock_cmd(4, DW'(v)); lock_cmd(6, DW'(v));
                check_wr("R11");
            end
        end
        // mismatched block aborts, then a lone D0 is not a confirm
        bus_wr(baddr(0, 0), 8'h60);
        bus_wr(baddr(1, 0), 8'h01);
        check_wr("R11");
        bus_wr(baddr(1, 0), 8'h01);
        check_wr("R11");
        lock_cmd(2, 8'h01);
        bus_wr(baddr(2, 0), 8'hD0);
        check_wr("R11");
        check_all_status("R11");

        // R9: other offsets read zero in identifier mode
        for (int o = 0; o < (1 << OFFW); o++) begin
            if (o != 2) begin
                addr_i = baddr(1, o); #1;
                check("R9", 32'(rdata_o), 32'h0);
            end
        end
        // R10: array mode reads zero
        bus_wr(baddr(0, 0), 8'hFF);
        for (int b = 0; b < NB; b++) begin
            addr_i = baddr(b, 2); #1;
            check("R10", 32'(rdata_o), 32'h0);
        end
        bus_wr(baddr(0, 0), 8'h90);
        check_status("R9", 7);

        // R8: reset clears lock-down; unlock works with pin high afterwards
        wp_i = 1'b1;
        do_reset();
        check("R1", 32'(writable_o), 32'h0);
        bus_wr(baddr(0, 0), 8'h90);
        check_all_status("R8");
        lock_cmd(1, 8'hD0); check_wr("R8");
        wp_i = 1'b0;

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule